// File: doc/BRIEF.md
# Class-Based Dual-Issue Controller

This block is the issue stage of an in-order two-way pipeline. Each cycle the fetch side may offer an aligned pair of instruction words. Every slot carries a valid bit, a predecoded class tag (floating-point ALU or everything else) and a predecoded mask naming the long-latency units the instruction needs. The block holds the pair in a register and, from that registered state, decides which slots go down the integer path and which go down the floating-point path. At most one instruction per class leaves per cycle. There is no dependency check between the two slots.

A slot whose required unit is busy is not reordered around. The pipeline slips until that unit frees, and the younger slot never overtakes the older one. A redirect from a taken branch throws away whatever pair is held. A fetch-advance output tells the fetch side when the holding register can take the next pair. The issue strobes, the issued words and the slip flag are registered, so they appear one cycle after the decision is made.

Top module: `dual_issue_ctl`

## Requirements
- R1: The class tag of a slot is 1 for a floating-point ALU instruction and 0 for any other instruction. A class-1 slot leaves only on `fp_go`/`fp_word`, and a class-0 slot leaves only on `int_go`/`int_word`.
- R2: At most one instruction of each class issues per cycle. When both held slots have the same class, slot 0 issues first and slot 1 issues alone in a later cycle.
- R3: A held pair with one slot of each class, both free, issues both slots in the same cycle, whichever slot holds which class.
- R4: Slot valid bits are honoured. A pair with only slot 1 valid (a branch target landing on the odd slot) offers a single candidate, and an invalid slot never issues.
- R5: Bit k of a slot's need mask asks for long-latency unit k. A slot that needs a unit whose busy bit is set does not issue. When a pair is held and nothing issues in a cycle, `slip` is high in the next cycle.
- R6: Issue is in order. Slot 1 never issues in an earlier cycle than a valid slot 0.
- R7: A busy unit that a slot does not request does not hold that slot back. For example, a busy floating-point divide/square-root unit (unit 1) does not block a floating-point ALU slot whose need mask is 0.
- R8: While `redirect` is high, the held pair is discarded. Neither slot issues, `fetch_adv` is low, and no part of that pair issues afterwards.
- R9: `fetch_adv` is high exactly when `redirect` is low and every valid held slot issues in the current cycle, or nothing is held. A held pair stays unchanged until it is consumed.
- R10: A pair offered while `fetch_adv` is high is captured at that clock edge. Its first decision is made in the next cycle, and the registered outputs show that decision one edge later. After reset, `int_go`, `fp_go` and `slip` are 0 and `fetch_adv` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A fetched pair is offered |
| fetch_slot_vld | input | 2 | Per-slot valid bits of the offered pair |
| fetch_fp | input | 2 | Per-slot class tag (1 = floating-point ALU) |
| fetch_need | input | 2*UNITS | Per-slot long-latency unit request masks, slot 0 in the low bits |
| fetch_word | input | 2*WORD_W | Instruction words, slot 0 in the low bits |
| unit_busy | input | UNITS | Busy flags of the long-latency units |
| redirect | input | 1 | Discard the held pair (branch redirect) |
| fetch_adv | output | 1 | Holding register takes a new pair at this edge |
| int_go | output | 1 | Integer-path issue strobe |
| int_word | output | WORD_W | Word issued to the integer path |
| fp_go | output | 1 | Floating-point-path issue strobe |
| fp_word | output | WORD_W | Word issued to the floating-point path |
| slip | output | 1 | A held pair issued nothing in the previous cycle |

## Verification
The hardest situation to reach is a pair where the older slot is blocked by a busy unit while the younger slot is of the other class and free. Only the in-order rule keeps the younger slot back, and the bench must then see both slots drain in slot order once the unit frees. The bench sweeps every combination of slot validity, class order, need bits and busy flags for two units. For each pair it holds the busy pattern for exactly the first decision cycle and then releases it, so every blocked-then-drained order is exercised. A separate sequence parks a blocked pair and then asserts a redirect under it.

// File: rtl/dic_pkg.sv
package dic_pkg;
  typedef enum logic {
    CLS_OTHER = 1'b0,
    CLS_FPALU = 1'b1
  } dic_cls_e;

  localparam int DIC_SLOTS = 2;
endpackage

// File: rtl/dic_hold.sv
module dic_hold #(
  parameter int WORD_W = 16,
  parameter int UNITS  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  flush,
  input  logic [1:0]            consume,
  input  logic [1:0]            in_vld,
  input  logic [1:0]            in_fp,
  input  logic [2*UNITS-1:0]    in_need,
  input  logic [2*WORD_W-1:0]   in_word,
  output logic [1:0]            h_vld,
  output logic [1:0]            h_fp,
  output logic [2*UNITS-1:0]    h_need,
  output logic [2*WORD_W-1:0]   h_word
);
  // valid bits carry reset; payload is plain data registers
  always_ff @(posedge clk) begin
    if (rst)        h_vld <= '0;
    else if (flush) h_vld <= '0;
    else if (load)  h_vld <= in_vld;
    else            h_vld <= h_vld & ~consume;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      h_fp   <= in_fp;
      h_need <= in_need;
      h_word <= in_word;
    end
  end

  // R9
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((|h_vld) && !load) |=> ($stable(h_word) && $stable(h_fp)));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (flush && !load) |=> (h_vld == 2'b00));
endmodule

// File: rtl/dic_pick.sv
module dic_pick
  import dic_pkg::*;
#(
  parameter int UNITS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic [1:0]          h_vld,
  input  logic [1:0]          h_fp,
  input  logic [2*UNITS-1:0]  h_need,
  input  logic [UNITS-1:0]    busy,
  output logic [1:0]          iss,
  output logic                drained,
  output logic                stall
);
  logic [1:0] free;
  dic_cls_e   cls [2];

  genvar s;
  generate
    for (s = 0; s < DIC_SLOTS; s++) begin : g_slot
      assign free[s] = ~|(h_need[s*UNITS +: UNITS] & busy);
      assign cls[s]  = dic_cls_e'(h_fp[s]);
    end
  endgenerate

  always_comb begin
    iss[0] = !flush && h_vld[0] && free[0];
    iss[1] = !flush && h_vld[1] && free[1] &&
             (!h_vld[0] || (iss[0] && (cls[0] != cls[1])));
    drained = (!h_vld[0] || iss[0]) && (!h_vld[1] || iss[1]);
    stall   = !flush && (|h_vld) && !(|iss);
  end

  // R2
  one_per_class_chk: assert property (@(posedge clk) disable iff (rst)
    (iss == 2'b11) |-> (h_fp[0] != h_fp[1]));

  // R6
  in_order_chk: assert property (@(posedge clk) disable iff (rst)
    (iss[1] && h_vld[0]) |-> iss[0]);

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    iss[0] |-> ((h_need[UNITS-1:0] & busy) == '0));

  // R4
  vld_only_chk: assert property (@(posedge clk) disable iff (rst)
    (iss & ~h_vld) == 2'b00);
endmodule

// File: rtl/dic_out.sv
module dic_out #(
  parameter int WORD_W = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [1:0]           iss,
  input  logic [1:0]           h_fp,
  input  logic [2*WORD_W-1:0]  h_word,
  input  logic                 stall,
  output logic                 int_go,
  output logic [WORD_W-1:0]    int_word,
  output logic                 fp_go,
  output logic [WORD_W-1:0]    fp_word,
  output logic                 slip
);
  logic [1:0] to_int, to_fp;
  logic [WORD_W-1:0] int_sel, fp_sel;

  assign to_int = iss & ~h_fp;
  assign to_fp  = iss &  h_fp;

  always_comb begin
    int_sel = to_int[0] ? h_word[WORD_W-1:0] : h_word[2*WORD_W-1:WORD_W];
    fp_sel  = to_fp[0]  ? h_word[WORD_W-1:0] : h_word[2*WORD_W-1:WORD_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_go <= 1'b0;
      fp_go  <= 1'b0;
      slip   <= 1'b0;
    end else begin
      int_go <= |to_int;
      fp_go  <= |to_fp;
      slip   <= stall;
    end
  end

  always_ff @(posedge clk) begin
    if (|to_int) int_word <= int_sel;
    if (|to_fp)  fp_word  <= fp_sel;
  end

  // R1
  int_route_chk: assert property (@(posedge clk) disable iff (rst)
    (iss[0] && !h_fp[0]) |=> int_go);

  // R5
  slip_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!int_go && !fp_go));
endmodule

// File: rtl/dual_issue_ctl.sv
module dual_issue_ctl #(
  parameter int WORD_W = 16,
  parameter int UNITS  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fetch_valid,
  input  logic [1:0]           fetch_slot_vld,
  input  logic [1:0]           fetch_fp,
  input  logic [2*UNITS-1:0]   fetch_need,
  input  logic [2*WORD_W-1:0]  fetch_word,
  input  logic [UNITS-1:0]     unit_busy,
  input  logic                 redirect,
  output logic                 fetch_adv,
  output logic                 int_go,
  output logic [WORD_W-1:0]    int_word,
  output logic                 fp_go,
  output logic [WORD_W-1:0]    fp_word,
  output logic                 slip
);
  logic [1:0]          h_vld, h_fp, iss;
  logic [2*UNITS-1:0]  h_need;
  logic [2*WORD_W-1:0] h_word;
  logic                drained, stall, load;

  assign fetch_adv = !redirect && drained;
  assign load      = fetch_adv && fetch_valid;

  dic_hold #(.WORD_W(WORD_W), .UNITS(UNITS)) u_hold (
    .clk(clk), .rst(rst), .load(load), .flush(redirect), .consume(iss),
    .in_vld(fetch_slot_vld), .in_fp(fetch_fp), .in_need(fetch_need),
    .in_word(fetch_word), .h_vld(h_vld), .h_fp(h_fp), .h_need(h_need),
    .h_word(h_word)
  );

  dic_pick #(.UNITS(UNITS)) u_pick (
    .clk(clk), .rst(rst), .flush(redirect), .h_vld(h_vld), .h_fp(h_fp),
    .h_need(h_need), .busy(unit_busy), .iss(iss), .drained(drained),
    .stall(stall)
  );

  dic_out #(.WORD_W(WORD_W)) u_out (
    .clk(clk), .rst(rst), .iss(iss), .h_fp(h_fp), .h_word(h_word),
    .stall(stall), .int_go(int_go), .int_word(int_word), .fp_go(fp_go),
    .fp_word(fp_word), .slip(slip)
  );

  // R8
  redirect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (!int_go && !fp_go));

  // R8
  redirect_no_adv_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |-> !fetch_adv);
endmodule

// File: tb/tb_dual_issue_ctl.sv
module tb_dual_issue_ctl;
  localparam int W = 16;
  localparam int U = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, redirect = 1'b0;
  logic [1:0] fetch_slot_vld = '0, fetch_fp = '0;
  logic [2*U-1:0] fetch_need = '0;
  logic [2*W-1:0] fetch_word = '0;
  logic [U-1:0] unit_busy = '0;
  logic fetch_adv, int_go, fp_go, slip;
  logic [W-1:0] int_word, fp_word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_issue_ctl #(.WORD_W(W), .UNITS(U)) dut (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid),
    .fetch_slot_vld(fetch_slot_vld), .fetch_fp(fetch_fp),
    .fetch_need(fetch_need), .fetch_word(fetch_word), .unit_busy(unit_busy),
    .redirect(redirect), .fetch_adv(fetch_adv), .int_go(int_go),
    .int_word(int_word), .fp_go(fp_go), .fp_word(fp_word), .slip(slip)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] mask_of(input bit need, input bit fp);
    return need ? (fp ? 2'b10 : 2'b01) : 2'b00;
  endfunction

  // one pair: busy pattern b for the first decision cycle, then free
  task automatic run_case(input int idx, input bit v0, input bit v1,
                          input bit c0, input bit c1, input bit n0,
                          input bit n1, input logic [1:0] b);
    logic [W-1:0] w0, w1;
    bit e0, e1, xi, xf;
    logic [W-1:0] xiw, xfw;
    int t0, t1, cnt;
    w0 = {idx[W-2:0], 1'b0};
    w1 = {idx[W-2:0], 1'b1};
    e0 = v0 && !(n0 && b[c0]);
    e1 = v1 && !(n1 && b[c1]) && (!v0 || (e0 && (c0 != c1)));
    xi = (e0 && !c0) || (e1 && !c1);
    xf = (e0 && c0) || (e1 && c1);
    xiw = (e0 && !c0) ? w0 : w1;
    xfw = (e0 && c0) ? w0 : w1;

    @(negedge clk);
    redirect = 1'b1; fetch_valid = 1'b0;
    #1 chk("R8 fetch_adv low under redirect", fetch_adv, 0);
    @(negedge clk);
    redirect = 1'b0; unit_busy = b; fetch_valid = 1'b1;
    fetch_slot_vld = {v1, v0}; fetch_fp = {c1, c0};
    fetch_need = {mask_of(n1, c1), mask_of(n0, c0)};
    fetch_word = {w1, w0};
    #1 chk("R9 fetch_adv high when empty", fetch_adv, 1);
    @(negedge clk);
    fetch_valid = 1'b0;
    // first decision cycle: drained iff every valid slot issues
    chk("R9 fetch_adv tracks drain", fetch_adv, ((!v0 || e0) && (!v1 || e1)) ? 1 : 0);
    @(negedge clk);
    chk("R1 int_go first cycle", int_go, xi);
    chk("R1 fp_go first cycle", fp_go, xf);
    if (xi) chk("R3 int_word first cycle", int_word, xiw);
    if (xf) chk("R7 fp_word first cycle", fp_word, xfw);
    chk("R5 slip first cycle", slip, (!e0 && !e1) ? 1 : 0);
    unit_busy = '0;
    t0 = -1; t1 = -1; cnt = 0;
    for (int st = 0; st < 4; st++) begin
      if (st > 0) @(negedge clk);
      if (int_go) begin
        cnt++;
        if (int_word == w0) t0 = st;
        if (int_word == w1) t1 = st;
      end
      if (fp_go) begin
        cnt++;
        if (fp_word == w0) t0 = st;
        if (fp_word == w1) t1 = st;
      end
    end
    chk("R4 issued count equals valid slots", cnt, v0 + v1);
    if (v0 && v1) begin
      if (c0 == c1) chk("R2 same class younger later", (t0 >= 0 && t1 > t0) ? 1 : 0, 1);
      else          chk("R6 older not after younger", (t0 >= 0 && t1 >= t0) ? 1 : 0, 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset int_go", int_go, 0);
    chk("R10 reset fp_go", fp_go, 0);
    chk("R10 reset slip", slip, 0);
    chk("R10 reset fetch_adv", fetch_adv, 1);

    idx = 0;
    for (int pat = 1; pat < 4; pat++)
      for (int c = 0; c < 4; c++)
        for (int n = 0; n < 4; n++)
          for (int b = 0; b < 4; b++) begin
            run_case(idx, pat[0], pat[1], c[0], c[1], n[0], n[1], b[1:0]);
            idx++;
          end

    // R8: park a blocked pair, then redirect under it
    @(negedge clk);
    unit_busy = 2'b01; fetch_valid = 1'b1; fetch_slot_vld = 2'b11;
    fetch_fp = 2'b10; fetch_need = 4'b0001; fetch_word = {16'h0BB1, 16'h0AA0};
    @(negedge clk);
    fetch_valid = 1'b0;
    chk("R5 blocked pair holds", fetch_adv, 0);
    @(negedge clk);
    chk("R5 slip while blocked", slip, 1);
    chk("R6 younger waits behind blocked older", fp_go, 0);
    redirect = 1'b1;
    #1 chk("R8 fetch_adv low with held pair", fetch_adv, 0);
    @(negedge clk);
    redirect = 1'b0; unit_busy = '0;
    for (int st = 0; st < 3; st++) begin
      @(negedge clk);
      chk("R8 discarded pair never issues", {int_go, fp_go}, 0);
    end
    chk("R8 empty after redirect", fetch_adv, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule